// File: doc/BRIEF.md
# Fixed-Point Dense Layer with ReLU

This block evaluates one fully connected neural-network layer using integer arithmetic only. An input vector is written into a small internal buffer, and a signed weight for every (neuron, input) pair and a signed bias for every neuron are written into internal memories. A start pulse then evaluates the neurons in ascending order. Each neuron takes one clock per input for its multiply-accumulate and one further clock to rescale its sum.

The inputs are signed Q16.16 words. When the block is built for raw pixels, each word carries an 8-bit grayscale value. That value is normalised on the fly so that full white becomes exactly 1.0. Weights and biases are 16-bit integers holding the real coefficient times ten thousand. After the bias is added, the accumulated sum is brought to the output format by a rounded division. The output format carries 14 fractional bits. The result is saturated to the output width, and on hidden layers ReLU is applied.

Each finished neuron is presented for one cycle with its index. A one-cycle completion pulse follows the last neuron. Parameters set the input count (784 for a flattened 28×28 image), the neuron count (62 for a class layer), the output width (32 bits for the first hidden layer, 64 for deeper ones), ReLU on or off, and pixel or raw input.

Top module: `dense_relu_layer`

## Requirements
- R1: With PIXEL_IN=1, bits [7:0] of each input word are a pixel p from 0 to 255 and are used as the Q16.16 value floor(p·65536/255); p=255 gives exactly 65536 (1.0) and p=128 gives 32896.
- R2: The weight for neuron n and input k is written at weight address n·N_IN+k, and the bias for neuron n at bias address n; both are 16-bit two's complement.
- R3: The neuron result is round((Σ x_k·w_k + bias·65536) / 40000), where a remainder of exactly one half is rounded away from zero (a sum of 20000 gives 1, −20000 gives −1 and 19999 gives 0).
- R4: A rescaled value above 2^(OUT_W−1)−1 or below −2^(OUT_W−1) is replaced by that bound instead of wrapping.
- R5: With RELU=1 a negative rescaled value is output as zero; with RELU=0 negative values are output unchanged.
- R6: A start pulse accepted in cycle e puts the result of neuron j on out_data with out_valid high after clock edge e+(j+1)·(N_IN+1): one multiply-accumulate per clock plus one rescale clock per neuron.
- R7: out_valid is high for one cycle per neuron, and out_idx runs 0, 1, …, N_OUT−1 in that order.
- R8: done is high for exactly one cycle, the cycle right after the last neuron's out_valid, and busy is low from that cycle on.
- R9: A start pulse while busy is high changes neither the results nor their timing, and produces no extra out_valid or done.
- R10: With PIXEL_IN=0 each input word is used unchanged as a signed Q16.16 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin evaluating all neurons (ignored while busy) |
| x_wr_en | input | 1 | Input buffer write enable |
| x_wr_addr | input | KW | Input index |
| x_wr_data | input | 32 | Input word (pixel in [7:0] or signed Q16.16) |
| w_wr_en | input | 1 | Weight write enable |
| w_wr_addr | input | WAW | Weight address n·N_IN+k |
| w_wr_data | input | 16 | Signed weight ×10,000 |
| b_wr_en | input | 1 | Bias write enable |
| b_wr_addr | input | NW | Neuron index of the bias |
| b_wr_data | input | 16 | Signed bias ×10,000 |
| busy | output | 1 | Evaluation in progress |
| out_valid | output | 1 | One-cycle strobe per finished neuron |
| out_idx | output | NW | Index of the finished neuron |
| out_data | output | OUT_W | Neuron result, signed, 14 fractional bits |
| done | output | 1 | One-cycle pulse after the last neuron |

## Verification
A stuck or skipped input counter or weight pointer shows up on the first neuron. Its strobe arrives at the wrong edge, or its value no longer matches a single weighted pixel, within N_IN+1 cycles of start. A wrong bias alignment, rounding direction or saturation bound shows up as a wrong out_data on the neuron built to hit that case. A neuron counter that fails to reset or advance shows up as a misordered out_idx or a misplaced done pulse. A start that is wrongly accepted during a run restarts the counters, and this shows as late strobes.

// File: rtl/dense_relu_layer.sv
module dense_relu_layer #(
  parameter int N_IN     = 32,
  parameter int N_OUT    = 8,
  parameter int OUT_W    = 32,
  parameter int ACC_W    = 80,
  parameter int RELU     = 1,
  parameter int PIXEL_IN = 1,
  localparam int KW     = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int NW     = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int WDEPTH = N_IN * N_OUT,
  localparam int WAW    = (WDEPTH > 1) ? $clog2(WDEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             x_wr_en,
  input  logic [KW-1:0]    x_wr_addr,
  input  logic [31:0]      x_wr_data,
  input  logic             w_wr_en,
  input  logic [WAW-1:0]   w_wr_addr,
  input  logic [15:0]      w_wr_data,
  input  logic             b_wr_en,
  input  logic [NW-1:0]    b_wr_addr,
  input  logic [15:0]      b_wr_data,
  output logic             busy,
  output logic             out_valid,
  output logic [NW-1:0]    out_idx,
  output logic [OUT_W-1:0] out_data,
  output logic             done
);

  localparam logic [ACC_W-1:0] HALF    = ACC_W'(20000);
  localparam logic [ACC_W-1:0] DIV     = ACC_W'(40000);
  localparam logic [ACC_W-1:0] POS_LIM = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = POS_LIM + ACC_W'(1);
  localparam logic [OUT_W-1:0] MAXV    = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINV    = {1'b1, {(OUT_W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_MAC, S_RESC, S_DONE} state_t;

  state_t state;
  logic [KW-1:0]  k;
  logic [NW-1:0]  n;
  logic [WAW-1:0] wp;
  logic signed [ACC_W-1:0] acc;

  logic [31:0] x_mem [N_IN];
  logic [15:0] w_mem [WDEPTH];
  logic [15:0] b_mem [N_OUT];

  always_ff @(posedge clk) begin
    if (x_wr_en && 32'(x_wr_addr) < N_IN)   x_mem[x_wr_addr] <= x_wr_data;
    if (w_wr_en && 32'(w_wr_addr) < WDEPTH) w_mem[w_wr_addr] <= w_wr_data;
    if (b_wr_en && 32'(b_wr_addr) < N_OUT)  b_mem[b_wr_addr] <= b_wr_data;
  end

  // Pixel normalisation: floor(p*65536/255) equals p*257 for p<255 and 65536 for p=255.
  logic [31:0] x_rd;
  logic signed [31:0] pix_q, xq;
  logic signed [15:0] wq;
  logic signed [47:0] prod;

  assign x_rd  = x_mem[k];
  assign pix_q = (x_rd[7:0] == 8'hFF) ? 32'sh0001_0000 : $signed({16'd0, x_rd[7:0], x_rd[7:0]});
  assign xq    = (PIXEL_IN != 0) ? pix_q : $signed(x_rd);
  assign wq    = $signed(w_mem[wp]);
  assign prod  = 48'(xq) * 48'(wq);

  // Rescale from 2^16 * 10^4 to 2^14: divide by 40000, half away from zero.
  logic [15:0] b_rd;
  logic signed [ACC_W-1:0] total;
  logic [ACC_W-1:0] mag, quo;
  logic neg;
  logic [OUT_W-1:0] res;

  assign b_rd  = b_mem[n];
  assign total = acc + $signed({{(ACC_W-32){b_rd[15]}}, b_rd, 16'd0});
  assign neg   = total[ACC_W-1];
  assign mag   = neg ? ACC_W'(-total) : ACC_W'(total);
  assign quo   = (mag + HALF) / DIV;

  always_comb begin
    if (!neg)
      res = (quo > POS_LIM) ? MAXV : quo[OUT_W-1:0];
    else if (RELU != 0)
      res = '0;
    else
      res = (quo >= NEG_LIM) ? MINV : OUT_W'(-quo[OUT_W-1:0]);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      k         <= '0;
      n         <= '0;
      wp        <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_MAC;
          k     <= '0;
          n     <= '0;
          wp    <= '0;
          acc   <= '0;
        end
        S_MAC: begin
          acc <= acc + $signed({{(ACC_W-48){prod[47]}}, prod});
          wp  <= wp + WAW'(1);
          if (k == KW'(N_IN - 1)) state <= S_RESC;
          else                    k <= k + KW'(1);
        end
        S_RESC: begin
          out_valid <= 1'b1;
          out_idx   <= n;
          out_data  <= res;
          k         <= '0;
          acc       <= '0;
          if (n == NW'(N_OUT - 1)) state <= S_DONE;
          else begin
            n     <= n + NW'(1);
            state <= S_MAC;
          end
        end
        default: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  AST_MAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MAC && k != KW'(N_IN - 1)) |=> (state == S_MAC && k == $past(k) + KW'(1))); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MAC && start) |=> (state != S_IDLE && n == $past(n))); // R9

  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && RELU != 0) |-> !out_data[OUT_W-1]); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid) && $past(out_idx) == NW'(N_OUT - 1))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !out_valid)); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, done})); // R7

endmodule

// File: tb/tb_dense_relu_layer.sv
module tb_dense_relu_layer;
  localparam int MI = 8, MO = 4, MW = 32;
  localparam int RI = 4, RO = 5, RW = 16;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  int cyc = 0, compared = 0, mismatched = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // main instance: pixel input, ReLU
  logic m_start = 0, m_xe = 0, m_we = 0, m_be = 0;
  logic [2:0] m_xa = 0; logic [4:0] m_wa = 0; logic [1:0] m_ba = 0;
  logic [31:0] m_xd = 0; logic [15:0] m_wd = 0, m_bd = 0;
  logic m_busy, m_ov, m_done; logic [1:0] m_idx; logic [MW-1:0] m_out;

  dense_relu_layer #(.N_IN(MI), .N_OUT(MO), .OUT_W(MW), .RELU(1), .PIXEL_IN(1)) dut (
    .clk, .rst_n, .start(m_start), .x_wr_en(m_xe), .x_wr_addr(m_xa), .x_wr_data(m_xd),
    .w_wr_en(m_we), .w_wr_addr(m_wa), .w_wr_data(m_wd), .b_wr_en(m_be), .b_wr_addr(m_ba),
    .b_wr_data(m_bd), .busy(m_busy), .out_valid(m_ov), .out_idx(m_idx), .out_data(m_out),
    .done(m_done));

  // raw instance: Q16.16 input, no ReLU, narrow output
  logic r_start = 0, r_xe = 0, r_we = 0, r_be = 0;
  logic [1:0] r_xa = 0; logic [4:0] r_wa = 0; logic [2:0] r_ba = 0;
  logic [31:0] r_xd = 0; logic [15:0] r_wd = 0, r_bd = 0;
  logic r_busy, r_ov, r_done; logic [2:0] r_idx; logic [RW-1:0] r_out;

  dense_relu_layer #(.N_IN(RI), .N_OUT(RO), .OUT_W(RW), .RELU(0), .PIXEL_IN(0)) dut_raw (
    .clk, .rst_n, .start(r_start), .x_wr_en(r_xe), .x_wr_addr(r_xa), .x_wr_data(r_xd),
    .w_wr_en(r_we), .w_wr_addr(r_wa), .w_wr_data(r_wd), .b_wr_en(r_be), .b_wr_addr(r_ba),
    .b_wr_data(r_bd), .busy(r_busy), .out_valid(r_ov), .out_idx(r_idx), .out_data(r_out),
    .done(r_done));

  // bench copies of loaded data
  longint mx [MI]; longint mw [MO][MI]; longint mb [MO];
  longint rx [RI]; longint rw [RO][RI]; longint rb [RO];

  // capture at negedge
  longint m_got [MO]; int m_vc [MO]; int m_ord [16]; int m_nv = 0, m_nd = 0, m_dc = 0;
  longint r_got [RO]; int r_vc [RO]; int r_ord [16]; int r_nv = 0, r_nd = 0, r_dc = 0;
  always @(negedge clk) begin
    if (m_ov) begin
      m_got[m_idx] = longint'($signed(m_out)); m_vc[m_idx] = cyc;
      if (m_nv < 16) m_ord[m_nv] = int'(m_idx);
      m_nv++;
    end
    if (m_done) begin m_nd++; m_dc = cyc; end
    if (r_ov) begin
      r_got[r_idx] = longint'($signed(r_out)); r_vc[r_idx] = cyc;
      if (r_nv < 16) r_ord[r_nv] = int'(r_idx);
      r_nv++;
    end
    if (r_done) begin r_nd++; r_dc = cyc; end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint rescale(longint s, int ow, bit relu);
    longint mag, q, r, hi, lo;
    mag = (s < 0) ? -s : s;
    q = (mag + 20000) / 40000;
    r = (s < 0) ? -q : q;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -(longint'(1) <<< (ow - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    if (relu && r < 0) r = 0;
    return r;
  endfunction

  function automatic longint m_expect(int n);
    longint s = mb[n] * 65536;
    for (int k = 0; k < MI; k++) s += ((mx[k] * 65536) / 255) * mw[n][k];
    return rescale(s, MW, 1'b1);
  endfunction

  function automatic longint r_expect(int n);
    longint s = rb[n] * 65536;
    for (int k = 0; k < RI; k++) s += rx[k] * rw[n][k];
    return rescale(s, RW, 1'b0);
  endfunction

  task automatic m_load();
    for (int k = 0; k < MI; k++) begin
      @(negedge clk); m_xe = 1; m_xa = 3'(k); m_xd = 32'(mx[k]);
    end
    for (int n = 0; n < MO; n++) for (int k = 0; k < MI; k++) begin
      @(negedge clk); m_xe = 0; m_we = 1; m_wa = 5'(n * MI + k); m_wd = 16'(mw[n][k]);
    end
    for (int n = 0; n < MO; n++) begin
      @(negedge clk); m_xe = 0; m_we = 0; m_be = 1; m_ba = 2'(n); m_bd = 16'(mb[n]);
    end
    @(negedge clk); m_xe = 0; m_we = 0; m_be = 0;
  endtask

  task automatic r_load();
    for (int k = 0; k < RI; k++) begin
      @(negedge clk); r_xe = 1; r_xa = 2'(k); r_xd = 32'(rx[k]);
    end
    for (int n = 0; n < RO; n++) for (int k = 0; k < RI; k++) begin
      @(negedge clk); r_xe = 0; r_we = 1; r_wa = 5'(n * RI + k); r_wd = 16'(rw[n][k]);
    end
    for (int n = 0; n < RO; n++) begin
      @(negedge clk); r_xe = 0; r_we = 0; r_be = 1; r_ba = 3'(n); r_bd = 16'(rb[n]);
    end
    @(negedge clk); r_xe = 0; r_we = 0; r_be = 0;
  endtask

  // run the main instance; optionally pulse start again mid-run
  task automatic m_run(string tag, bit poke);
    int s0;
    m_nv = 0; m_nd = 0;
    @(negedge clk); m_start = 1; s0 = cyc + 1;
    @(negedge clk); m_start = 0;
    if (poke) begin
      repeat (MI + 3) @(negedge clk);
      m_start = 1; @(negedge clk); m_start = 0;
    end
    wait (m_nd > 0); @(negedge clk); @(negedge clk);
    for (int n = 0; n < MO; n++) begin
      chk("R3", {tag, " value"}, m_got[n], m_expect(n));
      chk("R6", {tag, " strobe edge"}, m_vc[n], s0 + (n + 1) * (MI + 1));
      chk("R7", {tag, " order"}, m_ord[n], n);
    end
    chk(poke ? "R9" : "R7", {tag, " strobe count"}, m_nv, MO);
    chk(poke ? "R9" : "R8", {tag, " done count"}, m_nd, 1);
    chk("R8", {tag, " done edge"}, m_dc, s0 + MO * (MI + 1) + 1);
    chk("R8", {tag, " busy after"}, m_busy, 0);
  endtask

  task automatic test_reset();
    chk("R8", "reset busy", m_busy, 0);
    chk("R7", "reset out_valid", m_ov, 0);
    chk("R8", "reset done", m_done, 0);
  endtask

  task automatic test_pixel_basic();
    int pix [MI] = '{255, 128, 0, 17, 200, 99, 3, 64};
    for (int k = 0; k < MI; k++) mx[k] = pix[k];
    for (int n = 0; n < MO; n++) for (int k = 0; k < MI; k++) mw[n][k] = 0;
    mw[0][0] = 10000; mb[0] = 0;
    mw[1][1] = 10000; mb[1] = 0;
    for (int k = 0; k < MI; k++) mw[2][k] = -3000;
    mb[2] = -500;
    for (int k = 0; k < MI; k++) mw[3][k] = 500 * k + 100;
    mb[3] = 1234;
    m_load();
    m_run("pixel", 1'b0);
    chk("R1", "pixel 255 as 1.0", m_got[0], 16384);
    chk("R1", "pixel 128", m_got[1], 8224);
    chk("R5", "relu clamps negative", m_got[2], 0);
    chk("R2", "bias and weight addressing", m_got[3], m_expect(3));
  endtask

  task automatic test_start_ignored();
    for (int k = 0; k < MI; k++) mx[k] = (k * 37) % 256;
    for (int k = 0; k < MI; k++) mw[2][k] = (k % 2 == 0) ? 700 : -200;
    mb[2] = -20;
    m_load();
    m_run("restart", 1'b1);
  endtask

  task automatic test_raw_rounding_sat();
    int s0;
    rx[0] = 1; rx[1] = 64'h7FFFFFFF; rx[2] = -65536; rx[3] = 0;
    for (int n = 0; n < RO; n++) begin
      rb[n] = 0;
      for (int k = 0; k < RI; k++) rw[n][k] = 0;
    end
    rw[0][0] = 20000; rw[1][0] = -20000; rw[2][0] = 19999;
    rw[3][1] = 32767; rw[4][1] = -32768;
    r_load();
    r_nv = 0; r_nd = 0;
    @(negedge clk); r_start = 1; s0 = cyc + 1;
    @(negedge clk); r_start = 0;
    wait (r_nd > 0); @(negedge clk);
    chk("R3", "tie +0.5 rounds up", r_got[0], 1);
    chk("R3", "tie -0.5 rounds away", r_got[1], -1);
    chk("R3", "below half rounds to 0", r_got[2], 0);
    chk("R4", "saturate high", r_got[3], 32767);
    chk("R4", "saturate low", r_got[4], -32768);
    chk("R5", "no relu keeps negative", r_got[1], -1);
    chk("R6", "raw last strobe edge", r_vc[RO-1], s0 + RO * (RI + 1));
    chk("R8", "raw done edge", r_dc, s0 + RO * (RI + 1) + 1);
    for (int n = 0; n < RO; n++) chk("R7", "raw order", r_ord[n], n);
  endtask

  task automatic test_raw_negative_input();
    rw[0][0] = 0; rw[0][2] = 10000; rb[0] = 0;
    rw[2][2] = -5000; rb[2] = 3000;
    r_load();
    r_nv = 0; r_nd = 0;
    @(negedge clk); r_start = 1;
    @(negedge clk); r_start = 0;
    wait (r_nd > 0); @(negedge clk);
    chk("R10", "raw -1.0 input", r_got[0], -16384);
    chk("R10", "raw input with bias", r_got[2], r_expect(2));
    chk("R10", "raw strobe count", r_nv, RO);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_pixel_basic();
    test_start_ignored();
    test_raw_rounding_sat();
    test_raw_negative_input();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) if (cyc > 20000) begin
    compared++; mismatched++;
    $display("FAIL R6 watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule